// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt after a programmed number of rising edges on a picture-unit address line (bit A12). That line toggles a fixed number of times per scanline, so the interrupt marks a chosen scanline. The CPU programs the block through a write port. Four write targets sit in the top quarter of the address space. Address bit 13 selects the reload half or the enable half, and address bit 0 selects the function inside that half.

The address line reaches the block as a clean, already-filtered input. The block samples it on the system clock. A down-counter runs from a reload value. When it reaches zero while the block is enabled, a pending flag is set. A delay stage then counts a fixed number of `step_tick` pulses before it raises `irq`. `irq` stays high until software disables the block, and that disable write also acknowledges the interrupt.

The write port has no back-pressure. A write is accepted in any cycle where `wr_en` is high, and `irq` is a plain level output.

Top module: `line_irq_timer`

## Requirements
- R1: A write with address bits [15:13]=110 and bit 0=0 stores `wr_data` as the reload value. It does not change the counter.
- R2: A write with bits [15:13]=110 and bit 0=1 sets a reload request, whatever the data. The counter keeps its value until the next counting edge. On that edge the counter loads the reload value and the request clears.
- R3: On a counting edge with no reload request, a zero counter loads the reload value and a non-zero counter decrements by one.
- R4: If the counter is zero after a counting-edge update and the block is enabled, the pending flag is set. If the block is disabled, no interrupt results.
- R5: A write with bits [15:13]=111 and bit 0=0 clears the enable flag, the pending flag and the delay stage. `irq` is low from the edge that takes the write.
- R6: A write with bits [15:13]=111 and bit 0=1 sets the enable flag.
- R7: One cycle after pending rises, the delay stage arms with a count of 5. `irq` rises at the clock edge that samples the fifth `step_tick` while the stage is armed. It then stays high until the R5 write, and a further pending event does not restart the count.
- R8: With a reload value of zero, the counter stays at zero and every counting edge raises an interrupt while the block is enabled.
- R9: A counting edge is an `a12` value of 1 sampled at a clock edge, where the previous sample was 0. Holding `a12` high counts once.
- R10: After reset the reload value, the counter, all flags and the delay stage are cleared, and `irq` is 0.
- R11: A write is ignored when address bits [15:14] are not 11.
- R12: When a write and a counting edge fall in the same cycle, the edge uses the flag and reload values from before the write. An interrupt set by the edge wins over an acknowledge in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| a12 | input | 1 | Clean address line whose rising edges are counted |
| step_tick | input | 1 | Advance pulse for the output delay stage |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
The counter is internal, so its state is visible only through the time at which `irq` rises. The hardest cases are a reload request that is still outstanding while the counter sits at zero, and the delay stage receiving step ticks while already armed. Directed phases drive exact edge sequences that reach these states: a reload value of zero, disabled counting down to zero, and a long high pulse on `a12`. A seeded random phase then mixes writes, edges and ticks at small reload values so that zero crossings happen often. The bench compares `irq` every cycle against a bench-side model of the requirements.

// File: rtl/lti_pkg.sv
package lti_pkg;
  typedef enum logic [1:0] {
    DLY_IDLE = 2'd0,
    DLY_RUN  = 2'd1,
    DLY_FIRE = 2'd2
  } dly_state_t;

  typedef struct packed {
    logic latch_wr;
    logic reload_wr;
    logic dis_wr;
    logic en_wr;
  } lti_cmd_t;
endpackage

// File: rtl/lti_decode.sv
module lti_decode #(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output lti_pkg::lti_cmd_t cmd
);
  logic hit;
  logic upper;
  logic odd;

  always_comb begin
    hit   = wr_en && (wr_addr[ADDR_W-1:ADDR_W-2] == 2'b11);
    upper = wr_addr[ADDR_W-3];
    odd   = wr_addr[0];
    cmd.latch_wr  = hit && !upper && !odd;
    cmd.reload_wr = hit && !upper &&  odd;
    cmd.dis_wr    = hit &&  upper && !odd;
    cmd.en_wr     = hit &&  upper &&  odd;
  end
endmodule

// File: rtl/lti_edge.sv
module lti_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_in;
  end

  assign rise = line_in && !line_q;

  // R9: a rise cannot repeat on consecutive cycles
  a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lti_counter.sv
module lti_counter #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lti_pkg::lti_cmd_t cmd,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cnt_edge,
  output logic              pending
);
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             reload_q;
  logic             en_q;
  logic             pend_q;
  logic             set_evt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cnt_edge) begin
      if (reload_q || (cnt_q == '0)) cnt_nxt = latch_q;
      else                           cnt_nxt = cnt_q - 1'b1;
    end
    set_evt = cnt_edge && (cnt_nxt == '0) && en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (cmd.latch_wr) latch_q <= wr_data;
      cnt_q <= cnt_nxt;
      if (cmd.reload_wr)    reload_q <= 1'b1;
      else if (cnt_edge)    reload_q <= 1'b0;
      if (cmd.en_wr)        en_q <= 1'b1;
      else if (cmd.dis_wr)  en_q <= 1'b0;
      if (set_evt)          pend_q <= 1'b1;
      else if (cmd.dis_wr)  pend_q <= 1'b0;
    end
  end

  assign pending = pend_q;

  // R2: without a counting edge the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_edge |=> $stable(cnt_q));
  // R3: non-zero counter without request steps down by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_edge && !reload_q && (cnt_q != '0)) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R5: acknowledge without a new event clears pending
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.dis_wr && !set_evt) |=> !pend_q);
  // R4: pending rises only from an enabled counting edge
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt_edge && en_q));
endmodule

// File: rtl/lti_delay.sv
module lti_delay #(
  parameter int TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic ack,
  input  logic step_tick,
  output logic irq
);
  import lti_pkg::*;
  localparam int DW = $clog2(TICKS + 1);

  dly_state_t    st_q;
  logic [DW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DLY_IDLE;
      left_q <= '0;
    end else if (ack) begin
      st_q   <= DLY_IDLE;
      left_q <= '0;
    end else begin
      case (st_q)
        DLY_IDLE: if (pending) begin
          st_q   <= DLY_RUN;
          left_q <= DW'(TICKS);
        end
        DLY_RUN: if (step_tick) begin
          left_q <= left_q - 1'b1;
          if (left_q == DW'(1)) st_q <= DLY_FIRE;
        end
        default: st_q <= DLY_FIRE;
      endcase
    end
  end

  assign irq = (st_q == DLY_FIRE);

  // R7: the output only rises on a sampled tick
  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(step_tick));
  // R7: held until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  // R5: acknowledge drops the output
  a_r5_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer #(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int DELAY_TICKS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              a12,
  input  logic              step_tick,
  output logic              irq
);
  lti_pkg::lti_cmd_t cmd;
  logic              cnt_edge;
  logic              pending;

  lti_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  lti_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (a12),
    .rise    (cnt_edge)
  );

  lti_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wr_data  (wr_data),
    .cnt_edge (cnt_edge),
    .pending  (pending)
  );

  lti_delay #(.TICKS(DELAY_TICKS)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (pending),
    .ack       (cmd.dis_wr),
    .step_tick (step_tick),
    .irq       (irq)
  );

  // R10: output low in the cycle after reset
  a_r10_reset_low: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/test_line_irq_timer.sv
module test_line_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        a12 = 1'b0;
  logic        step_tick = 1'b0;
  logic        irq;

  int total = 0;
  int fails = 0;

  // bench model state
  logic [7:0] m_latch, m_cnt;
  logic       m_rel, m_en, m_pend, m_a12q;
  int         m_st, m_left;
  logic       m_irq;

  always #4 clk = ~clk;

  line_irq_timer i_line_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .a12(a12), .step_tick(step_tick), .irq(irq)
  );

  task automatic model_reset();
    m_latch = 0; m_cnt = 0; m_rel = 0; m_en = 0; m_pend = 0;
    m_a12q = 0; m_st = 0; m_left = 0; m_irq = 0;
  endtask

  task automatic model_step(input logic we, input logic [15:0] a,
                            input logic [7:0] d, input logic av, input logic tk);
    logic edg, sel, lw, rw, dw, ew, setp;
    logic [7:0] nc;
    edg = av && !m_a12q;
    sel = we && (a[15:14] == 2'b11);
    lw = sel && !a[13] && !a[0];
    rw = sel && !a[13] &&  a[0];
    dw = sel &&  a[13] && !a[0];
    ew = sel &&  a[13] &&  a[0];
    nc = m_cnt;
    if (edg) nc = (m_rel || m_cnt == 0) ? m_latch : m_cnt - 8'd1;
    setp = edg && (nc == 0) && m_en;
    // delay stage uses old pending
    if (dw) begin m_st = 0; m_left = 0; end
    else if (m_st == 0) begin if (m_pend) begin m_st = 1; m_left = 5; end end
    else if (m_st == 1) begin
      if (tk) begin if (m_left == 1) m_st = 2; m_left = m_left - 1; end
    end
    m_irq = (m_st == 2);
    if (lw) m_latch = d;
    m_cnt = nc;
    if (rw) m_rel = 1; else if (edg) m_rel = 0;
    if (ew) m_en = 1; else if (dw) m_en = 0;
    if (setp) m_pend = 1; else if (dw) m_pend = 0;
    m_a12q = av;
  endtask

  task automatic check(input string tag);
    total++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s: irq actual=%b expected=%b at %0t", tag, irq, m_irq, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input logic av, input logic tk, input string tag);
    wr_en = we; wr_addr = a; wr_data = d; a12 = av; step_tick = tk;
    @(posedge clk);
    model_step(we, a, d, av, tk);
    #2;
    check(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, a, d, a12, 1'b0, tag);
  endtask

  task automatic pulse(input int high_len, input string tag);
    for (int i = 0; i < high_len; i++) cyc(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, tag);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 16'h0, 8'h0, a12, 1'b1, tag);
      cyc(1'b0, 16'h0, 8'h0, a12, 1'b0, tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R10 reset");

    // R1 R2 R6: latch 2, reload request, enable
    wr(16'hC000, 8'd2, "R1 latch");
    wr(16'hC001, 8'h5A, "R2 reload request");
    wr(16'hE001, 8'h00, "R6 enable");
    pulse(1, "R2 reload edge");
    pulse(1, "R3 decrement");
    ticks(3, "R7 no irq before zero");
    pulse(1, "R4 reaches zero");
    ticks(4, "R7 four ticks low");
    ticks(1, "R7 fifth tick high");
    ticks(3, "R7 held");
    pulse(1, "R7 extra event no restart");
    ticks(2, "R7 held still");
    // R11: out-of-range writes ignored (would-be ack/disable aliases)
    wr(16'h6000, 8'hFF, "R11 ignored write");
    wr(16'h2000, 8'h00, "R11 ignored write");
    wr(16'h4000, 8'h00, "R11 ignored write");
    wr(16'hE000, 8'h00, "R5 ack");
    ticks(6, "R5 stays low");

    // R4: disabled counting reaches zero: no interrupt
    wr(16'hC000, 8'd1, "R1 latch 1");
    wr(16'hC001, 8'h00, "R2 reload");
    for (int i = 0; i < 4; i++) pulse(1, "R4 disabled");
    ticks(6, "R4 disabled no irq");

    // R9: long high counts once
    wr(16'hC000, 8'd2, "R1 latch 2");
    wr(16'hC001, 8'h00, "R2 reload");
    wr(16'hE001, 8'h00, "R6 enable");
    pulse(1, "R9 load");
    pulse(6, "R9 long high");
    ticks(6, "R9 no irq yet");
    pulse(1, "R9 zero");
    ticks(6, "R9 irq");
    wr(16'hE000, 8'h00, "R5 ack");

    // R8: zero latch fires every edge
    wr(16'hC000, 8'd0, "R8 latch 0");
    wr(16'hC001, 8'h00, "R8 reload");
    wr(16'hE001, 8'h00, "R6 enable");
    for (int i = 0; i < 3; i++) begin
      pulse(1, "R8 edge");
      ticks(6, "R8 irq each edge");
      wr(16'hE000, 8'h00, "R5 ack");
      wr(16'hE001, 8'h00, "R6 re-enable");
    end

    // R12: edge and acknowledge in the same cycle: set wins
    cyc(1'b1, 16'hE000, 8'h00, 1'b1, 1'b0, "R12 edge with ack");
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R12");
    ticks(6, "R12 set wins");

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [15:0] ad;
      r = int'($urandom % 16);
      if (r < 3) begin
        case ($urandom % 5)
          0: ad = 16'hC000;
          1: ad = 16'hC001;
          2: ad = 16'hE001;
          3: ad = 16'h8001;
          default: ad = ($urandom % 4 == 0) ? 16'hE000 : 16'hC001;
        endcase
        cyc(1'b1, ad, 8'($urandom % 4), a12, 1'($urandom), "R12 random write");
      end else begin
        cyc(1'b0, 16'h0, 8'h0, 1'($urandom), 1'($urandom), "R3 random edge");
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule